// File: doc/BRIEF.md
# Multi-Channel Temperature Limit Status Logic

This block watches four temperature channels, one on-die and three remote, and keeps their limit status. Each channel has its own upper limit, lower limit and shutdown limit, and all channels share one shutdown hysteresis. Every conversion strobe presents a fresh set of readings. On that strobe the block updates three per-channel status registers: over-upper, under-lower and shutdown. It also derives a summary register from them and drives an alert line. The alert is qualified by a programmable run of consecutive out-of-range conversions.

Software reads the registers through a single-cycle strobe with a two-bit register select. Reading the over-upper or under-lower register clears it. The shutdown register is not affected by reads; each of its bits clears only when its channel cools below the shutdown limit minus the hysteresis. In latched mode the upper and lower bits stay set until read. In comparator mode they follow the most recent comparison. Limits, hysteresis, mode and qualifier count are static inputs.

Top module: `temp_limit_status`

## Requirements
- R1: Select codes: 0 is summary, 1 is over-upper, 2 is under-lower, 3 is shutdown. In each per-channel register, bit 0 is the on-die channel and bits 1 to 3 are remote channels 1 to 3. Bits 7 to 4 of every read return zero.
- R2: On a conversion strobe, a channel's over-upper bit is set when its reading is greater than its upper limit, and its under-lower bit is set when its reading is less than its lower limit. Readings and limits are compared as 8-bit two's complement.
- R3: Summary bit 0 is high while any over-upper bit is set. Summary bit 1 is high while any under-lower bit is set. Summary bit 2 is high while any shutdown bit is set.
- R4: A read of select 1 or 2 returns the register contents before the read, clears that register at the same clock edge, and so also clears the matching summary bit. A bit set by a conversion at that same edge stays set.
- R5: With comp_mode_i low, over-upper and under-lower bits hold until read. With comp_mode_i high, each conversion loads them with that conversion's comparison results.
- R6: Each channel's counter goes up by one, saturating at 4, on every out-of-range conversion, and returns to 0 on every in-range conversion. alert_o is high exactly when some channel's count is at least fault_cnt_i+1 and that channel's over-upper or under-lower bit is set.
- R7: A conversion with a reading above the channel's shutdown limit sets that channel's shutdown bit. Reads never clear a shutdown bit.
- R8: A shutdown bit clears on a conversion whose reading is below the shutdown limit minus the hysteresis, computed without wrap-around. Readings between that threshold and the limit leave the bit unchanged.
- R9: After reset all registers read zero and alert_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_valid_i | input | 1 | New conversion strobe for all channels |
| temp_i | input | 32 | Readings, channel c at bits [8c+7:8c] |
| hi_lim_i | input | 32 | Upper limits, packed per channel |
| lo_lim_i | input | 32 | Lower limits, packed per channel |
| shut_lim_i | input | 32 | Shutdown limits, packed per channel |
| shut_hyst_i | input | 8 | Shared shutdown hysteresis, unsigned |
| comp_mode_i | input | 1 | 1 = comparator mode, 0 = latched mode |
| fault_cnt_i | input | 2 | Required consecutive count minus one |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 2 | Register select |
| rd_data_o | output | 8 | Selected register contents |
| alert_o | output | 1 | Qualified limit alert |

## Verification
The bench drives negative readings against positive limits, so a design that compared unsigned values would report a cold channel as hot. It places a read-clear in the same cycle as a new set; a design that let the clear win would lose that event. It walks a shutdown reading across the hysteresis band one degree at a time, and uses a shutdown limit near the negative end of the range, where an 8-bit threshold would wrap and clear the bit falsely. It also counts conversions to the qualifier threshold under each count setting, so an off-by-one counter raises the alert a conversion early or late.

// File: rtl/temp_status_pkg.sv
package temp_status_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    SEL_SUMMARY = 2'd0,
    SEL_HIGH    = 2'd1,
    SEL_LOW     = 2'd2,
    SEL_SHUT    = 2'd3
  } reg_sel_e;

  localparam int SUM_HI_BIT   = 0;
  localparam int SUM_LO_BIT   = 1;
  localparam int SUM_SHUT_BIT = 2;
endpackage

// File: rtl/chan_compare.sv
module chan_compare #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] hi_lim_i,
  input  logic [TW-1:0] lo_lim_i,
  input  logic [TW-1:0] shut_lim_i,
  input  logic [TW-1:0] shut_hyst_i,
  output logic          over_hi_o,
  output logic          under_lo_o,
  output logic          over_shut_o,
  output logic          below_rel_o
);
  // two guard bits: limit minus hysteresis cannot wrap
  localparam int EW = TW + 2;

  logic signed [EW-1:0] temp_x, shut_x, rel_x;

  assign temp_x = {{2{temp_i[TW-1]}}, temp_i};
  assign shut_x = {{2{shut_lim_i[TW-1]}}, shut_lim_i};
  assign rel_x  = shut_x - $signed({2'b00, shut_hyst_i});

  assign over_hi_o   = $signed(temp_i) > $signed(hi_lim_i);
  assign under_lo_o  = $signed(temp_i) < $signed(lo_lim_i);
  assign over_shut_o = temp_x > shut_x;
  assign below_rel_o = temp_x < rel_x;

  always_comb begin
    AST_SHUT_BANDS_DISJOINT: assert (!(over_shut_o && below_rel_o)); // R8
  end
endmodule

// File: rtl/consec_counter.sv
module consec_counter #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_i,
  input  logic             out_i,
  input  logic [CNT_W-1:0] need_i,
  output logic             qual_o
);
  localparam int            QW   = CNT_W + 1;
  localparam logic [QW-1:0] CMAX = QW'(2 ** CNT_W);

  logic [QW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (conv_i) begin
      if (!out_i)            cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign qual_o = cnt_q > {1'b0, need_i};

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX); // R6
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !out_i) |=> (cnt_q == '0)); // R6
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_i |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/status_bank.sv
module status_bank #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_i,
  input  logic              comp_mode_i,
  input  logic [NUM_CH-1:0] over_hi_i,
  input  logic [NUM_CH-1:0] under_lo_i,
  input  logic [NUM_CH-1:0] over_shut_i,
  input  logic [NUM_CH-1:0] below_rel_i,
  input  logic              clr_hi_i,
  input  logic              clr_lo_i,
  output logic [NUM_CH-1:0] hi_o,
  output logic [NUM_CH-1:0] lo_o,
  output logic [NUM_CH-1:0] shut_o
);
  logic [NUM_CH-1:0] hi_q, lo_q, shut_q;
  logic [NUM_CH-1:0] hi_keep, lo_keep, hi_d, lo_d, shut_d;

  assign hi_keep = clr_hi_i ? '0 : hi_q;
  assign lo_keep = clr_lo_i ? '0 : lo_q;

  // set always beats a concurrent read-clear
  always_comb begin
    if (!conv_i) begin
      hi_d = hi_keep;
      lo_d = lo_keep;
    end else if (comp_mode_i) begin
      hi_d = over_hi_i;
      lo_d = under_lo_i;
    end else begin
      hi_d = hi_keep | over_hi_i;
      lo_d = lo_keep | under_lo_i;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_shut
      always_comb begin
        shut_d[c] = shut_q[c];
        if (conv_i) begin
          if (over_shut_i[c])      shut_d[c] = 1'b1;
          else if (below_rel_i[c]) shut_d[c] = 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      shut_q <= '0;
    end else begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      shut_q <= shut_d;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign shut_o = shut_q;

  AST_HI_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_i |=> ((hi_q & $past(over_hi_i)) == $past(over_hi_i))); // R2
  AST_LO_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_i |=> ((lo_q & $past(under_lo_i)) == $past(under_lo_i))); // R2
  AST_HI_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hi_i && !conv_i) |=> (hi_q == '0)); // R4
  AST_LO_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_lo_i && !conv_i) |=> (lo_q == '0)); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!conv_i && !clr_hi_i) |=> $stable(hi_q)); // R5
  AST_CMP_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && comp_mode_i) |=> (lo_q == $past(under_lo_i))); // R5
  AST_SHUT_NO_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !conv_i |=> $stable(shut_q)); // R7
  AST_SHUT_REL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_i |=> ((shut_q & $past(below_rel_i)) == '0)); // R8
endmodule

// File: rtl/temp_limit_status.sv
module temp_limit_status
  import temp_status_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TW     = 8,
  parameter int CNT_W  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 conv_valid_i,
  input  logic [NUM_CH*TW-1:0] temp_i,
  input  logic [NUM_CH*TW-1:0] hi_lim_i,
  input  logic [NUM_CH*TW-1:0] lo_lim_i,
  input  logic [NUM_CH*TW-1:0] shut_lim_i,
  input  logic [TW-1:0]        shut_hyst_i,
  input  logic                 comp_mode_i,
  input  logic [CNT_W-1:0]     fault_cnt_i,
  input  logic                 rd_en_i,
  input  logic [1:0]           rd_sel_i,
  output logic [REG_W-1:0]     rd_data_o,
  output logic                 alert_o
);
  localparam int PAD_W = REG_W - NUM_CH;

  logic [NUM_CH-1:0] over_hi, under_lo, over_shut, below_rel, qual;
  logic [NUM_CH-1:0] hi_st, lo_st, shut_st;
  logic [REG_W-1:0]  summary;
  logic              clr_hi, clr_lo;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      chan_compare #(.TW(TW)) u_cmp (
        .temp_i      (temp_i[c*TW +: TW]),
        .hi_lim_i    (hi_lim_i[c*TW +: TW]),
        .lo_lim_i    (lo_lim_i[c*TW +: TW]),
        .shut_lim_i  (shut_lim_i[c*TW +: TW]),
        .shut_hyst_i (shut_hyst_i),
        .over_hi_o   (over_hi[c]),
        .under_lo_o  (under_lo[c]),
        .over_shut_o (over_shut[c]),
        .below_rel_o (below_rel[c])
      );

      consec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .conv_i (conv_valid_i),
        .out_i  (over_hi[c] | under_lo[c]),
        .need_i (fault_cnt_i),
        .qual_o (qual[c])
      );
    end
  endgenerate

  assign clr_hi = rd_en_i && (reg_sel_e'(rd_sel_i) == SEL_HIGH);
  assign clr_lo = rd_en_i && (reg_sel_e'(rd_sel_i) == SEL_LOW);

  status_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .conv_i      (conv_valid_i),
    .comp_mode_i (comp_mode_i),
    .over_hi_i   (over_hi),
    .under_lo_i  (under_lo),
    .over_shut_i (over_shut),
    .below_rel_i (below_rel),
    .clr_hi_i    (clr_hi),
    .clr_lo_i    (clr_lo),
    .hi_o        (hi_st),
    .lo_o        (lo_st),
    .shut_o      (shut_st)
  );

  always_comb begin
    summary               = '0;
    summary[SUM_HI_BIT]   = |hi_st;
    summary[SUM_LO_BIT]   = |lo_st;
    summary[SUM_SHUT_BIT] = |shut_st;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel_i))
      SEL_SUMMARY: rd_data_o = summary;
      SEL_HIGH:    rd_data_o = {{PAD_W{1'b0}}, hi_st};
      SEL_LOW:     rd_data_o = {{PAD_W{1'b0}}, lo_st};
      default:     rd_data_o = {{PAD_W{1'b0}}, shut_st};
    endcase
  end

  assign alert_o = |(qual & (hi_st | lo_st));

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1:NUM_CH] == '0); // R1
  AST_ALERT_NEEDS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> (summary[SUM_HI_BIT] || summary[SUM_LO_BIT])); // R6
endmodule

// File: tb/temp_limit_status_tb.sv
module temp_limit_status_tb;
  localparam int NCH = 4;
  localparam int TW  = 8;
  localparam int CW  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                rst_n;
  logic                conv_valid, comp_mode, rd_en, alert;
  logic [1:0]          rd_sel;
  logic [CW-1:0]       fault_cnt;
  logic [7:0]          rd_data;
  logic [TW-1:0]       hyst_v;
  logic [NCH*TW-1:0]   temp_p, hi_p, lo_p, sh_p;
  logic signed [TW-1:0] t_v[NCH], hi_v[NCH], lo_v[NCH], sh_v[NCH];

  logic [NCH-1:0] m_hi, m_lo, m_sh;
  int             m_cnt[NCH];
  int             n_checks = 0, n_errors = 0;
  bit             done = 0;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_pack
      assign temp_p[g*TW +: TW] = t_v[g];
      assign hi_p[g*TW +: TW]   = hi_v[g];
      assign lo_p[g*TW +: TW]   = lo_v[g];
      assign sh_p[g*TW +: TW]   = sh_v[g];
    end
  endgenerate

  temp_limit_status u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .conv_valid_i (conv_valid),
    .temp_i       (temp_p),
    .hi_lim_i     (hi_p),
    .lo_lim_i     (lo_p),
    .shut_lim_i   (sh_p),
    .shut_hyst_i  (hyst_v),
    .comp_mode_i  (comp_mode),
    .fault_cnt_i  (fault_cnt),
    .rd_en_i      (rd_en),
    .rd_sel_i     (rd_sel),
    .rd_data_o    (rd_data),
    .alert_o      (alert)
  );

  function automatic logic [7:0] m_read(input logic [1:0] sel);
    case (sel)
      2'd0:    return {5'b0, |m_sh, |m_lo, |m_hi};
      2'd1:    return {4'b0, m_hi};
      2'd2:    return {4'b0, m_lo};
      default: return {4'b0, m_sh};
    endcase
  endfunction

  function automatic logic m_alert();
    for (int c = 0; c < NCH; c++)
      if (m_cnt[c] >= int'(fault_cnt) + 1 && (m_hi[c] || m_lo[c])) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check read before edge, model the edge, check alert after
  task automatic cyc(input bit conv, input bit rd, input logic [1:0] sel, input string tag);
    logic [NCH-1:0] n_hi, n_lo, n_sh;
    int             n_cnt[NCH];
    conv_valid = conv;
    rd_en      = rd;
    rd_sel     = sel;
    #1;
    if (rd) check(tag, rd_data, m_read(sel));
    for (int c = 0; c < NCH; c++) begin
      bit over, under, osh, brel, keep_h, keep_l;
      over   = int'(t_v[c]) > int'(hi_v[c]);
      under  = int'(t_v[c]) < int'(lo_v[c]);
      osh    = int'(t_v[c]) > int'(sh_v[c]);
      brel   = int'(t_v[c]) < int'(sh_v[c]) - int'(hyst_v);
      keep_h = (rd && sel == 2'd1) ? 1'b0 : m_hi[c];
      keep_l = (rd && sel == 2'd2) ? 1'b0 : m_lo[c];
      if (!conv) begin
        n_hi[c] = keep_h; n_lo[c] = keep_l; n_sh[c] = m_sh[c]; n_cnt[c] = m_cnt[c];
      end else begin
        n_hi[c]  = comp_mode ? over  : (keep_h | over);
        n_lo[c]  = comp_mode ? under : (keep_l | under);
        n_sh[c]  = osh ? 1'b1 : (brel ? 1'b0 : m_sh[c]);
        n_cnt[c] = (over || under) ? ((m_cnt[c] < 4) ? m_cnt[c] + 1 : 4) : 0;
      end
    end
    @(posedge clk);
    m_hi = n_hi; m_lo = n_lo; m_sh = n_sh;
    for (int c = 0; c < NCH; c++) m_cnt[c] = n_cnt[c];
    @(negedge clk);
    conv_valid = 1'b0;
    rd_en      = 1'b0;
    check("R6 alert", {7'b0, alert}, {7'b0, m_alert()});
  endtask

  task automatic set_temps(input int a, input int b, input int c, input int d);
    t_v[0] = TW'(a); t_v[1] = TW'(b); t_v[2] = TW'(c); t_v[3] = TW'(d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; conv_valid = 0; rd_en = 0; rd_sel = 0;
    comp_mode = 0; fault_cnt = 0; hyst_v = 8'd5;
    for (int c = 0; c < NCH; c++) begin
      hi_v[c] = 8'sd50; lo_v[c] = 8'sd10; sh_v[c] = 8'sd80; t_v[c] = 8'sd30;
      m_cnt[c] = 0;
    end
    m_hi = '0; m_lo = '0; m_sh = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 alert", {7'b0, alert}, 8'h00);
    for (int s = 0; s < 4; s++) cyc(0, 1, 2'(s), "R9 reset read");

    // R2 signed compare, R3 summary, R1 map
    set_temps(60, 5, -20, 30);
    cyc(1, 0, 2'd0, "");
    cyc(0, 1, 2'd0, "R3 summary");
    check("R1 high map", {4'b0, m_hi}, 8'h01);
    cyc(0, 1, 2'd1, "R2 high");
    cyc(0, 1, 2'd0, "R4 summary after high read");
    check("R2 low map", {4'b0, m_lo}, 8'h06);
    cyc(0, 1, 2'd2, "R2 low");
    cyc(0, 1, 2'd2, "R4 low cleared");

    // R5 latched hold vs comparator follow
    set_temps(60, 30, 30, 30);
    cyc(1, 0, 2'd0, "");
    set_temps(30, 30, 30, 30);
    cyc(1, 0, 2'd0, "");
    cyc(0, 1, 2'd1, "R5 latched hold");
    comp_mode = 1;
    set_temps(60, 30, 30, 5);
    cyc(1, 0, 2'd0, "");
    cyc(0, 1, 2'd2, "R5 comparator set");
    set_temps(30, 30, 30, 30);
    cyc(1, 0, 2'd0, "");
    cyc(0, 1, 2'd1, "R5 comparator follow");
    comp_mode = 0;

    // R4 set in same cycle as clear
    set_temps(60, 30, 30, 30);
    cyc(1, 1, 2'd1, "R4 read during set");
    check("R4 model set kept", {4'b0, m_hi}, 8'h01);
    cyc(0, 1, 2'd1, "R4 set survives read");

    // R7 / R8 shutdown with hysteresis (threshold 75)
    set_temps(30, 30, 30, 85);
    cyc(1, 0, 2'd0, "");
    cyc(0, 1, 2'd3, "R7 shut set");
    cyc(0, 1, 2'd3, "R7 shut read keeps");
    set_temps(30, 30, 30, 76);
    cyc(1, 1, 2'd3, "R8 in band");
    set_temps(30, 30, 30, 75);
    cyc(1, 1, 2'd3, "R8 at threshold");
    set_temps(30, 30, 30, 74);
    cyc(1, 1, 2'd3, "R8 held before clear");
    cyc(0, 1, 2'd3, "R8 cleared");
    check("R8 model cleared", {4'b0, m_sh}, 8'h00);
    // threshold below range: no wrap
    sh_v[2] = -8'sd120; hyst_v = 8'd20;
    set_temps(30, 30, -100, 30);
    cyc(1, 1, 2'd3, "R7 negative limit");
    set_temps(30, 30, -128, 30);
    cyc(1, 1, 2'd3, "R8 no wrap");
    cyc(0, 1, 2'd3, "R8 no wrap hold");
    sh_v[2] = 8'sd80; hyst_v = 8'd5;
    set_temps(30, 30, 30, 30);
    cyc(1, 1, 2'd2, "R2 low clear");
    cyc(0, 1, 2'd1, "R2 high clear");

    // R6 qualifier, need 3
    fault_cnt = 2;
    set_temps(30, 5, 30, 30);
    cyc(1, 0, 2'd0, "");
    cyc(1, 0, 2'd0, "");
    check("R6 not yet", {7'b0, alert}, 8'h00);
    cyc(1, 0, 2'd0, "");
    check("R6 reached", {7'b0, alert}, 8'h01);
    set_temps(30, 30, 30, 30);
    cyc(1, 0, 2'd0, "");
    check("R6 counter reset", {7'b0, alert}, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) < 3) comp_mode = $urandom_range(0, 1) != 0;
      if ($urandom_range(0, 99) < 3) fault_cnt = CW'($urandom_range(0, 3));
      if ($urandom_range(0, 99) < 2) hyst_v = 8'($urandom_range(0, 40));
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(0, 3) == 0) t_v[c] = TW'(int'($urandom_range(0, 150)) - 40);
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
          2'($urandom_range(0, 3)), "R2 random read");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule